// File: doc/BRIEF.md
# Line Interface Loopback Selector

This block sits between the transmit-side system pins, the line driver and receiver, and the receive-side digital logic of a line interface. It steers a three-signal lane (a sampled clock bit, a positive-rail data bus and a negative-rail data bus) along one of four diagnostic routes. A two-bit control, one local-enable bit and one remote-enable bit, is captured into a mode register, and every route is a registered multiplexer. As a result, a mode change never reaches the downstream receive logic partway through a cycle.

The analog front end is stood in for by a parameterised register chain, the front-end stub, that carries the line-side receive lane to the recovered lane. In remote loopback, the recovered lane is sent back out to the line while it still reaches the receive pins. In analog local loopback, the outgoing line lane is fed into the front-end stub in place of the line input. In digital local loopback, the transmit lane goes straight to the receive outputs, which also feed the signal-loss detector, the line decoder and the pattern checker.

Top module: `lbk_selector`

## Requirements
- R1: The control bits are registered. The mode status output equals {local-enable, remote-enable} as sampled at the most recent rising edge. Every route uses the mode held in that register.
- R2: Mode status 2'b00 (off): the line output is the transmit lane delayed by 1 cycle. The receive outputs are the line-receive lane delayed by AFE_STAGES+1 cycles.
- R3: Mode status 2'b01 (remote): the line output is the line-receive lane delayed by AFE_STAGES+1 cycles, and the transmit input has no effect on it.
- R4: In remote mode, the receive outputs still carry the line-receive lane delayed by AFE_STAGES+1 cycles.
- R5: Mode status 2'b10 (analog local): the receive outputs carry the transmit lane delayed by AFE_STAGES+2 cycles, and the line-receive input has no effect on them.
- R6: Mode status 2'b11 (digital local): the receive outputs carry the transmit lane delayed by 1 cycle, and the line-receive input has no effect on them.
- R7: In both local modes (status bit 1 set), the line output is the transmit lane delayed by 1 cycle.
- R8: A synchronous active-low reset clears every output lane to zero and the mode status to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_en_i | input | 1 | Local loopback enable |
| rem_en_i | input | 1 | Remote loopback enable |
| tx_clk_i | input | 1 | Transmit lane, sampled clock bit |
| tx_pos_i | input | WIDTH | Transmit lane, positive-rail data |
| tx_neg_i | input | WIDTH | Transmit lane, negative-rail data |
| line_rx_clk_i | input | 1 | Line receive lane, clock bit |
| line_rx_pos_i | input | WIDTH | Line receive lane, positive rail |
| line_rx_neg_i | input | WIDTH | Line receive lane, negative rail |
| line_tx_clk_o | output | 1 | Line output lane, clock bit |
| line_tx_pos_o | output | WIDTH | Line output lane, positive rail |
| line_tx_neg_o | output | WIDTH | Line output lane, negative rail |
| rx_clk_o | output | 1 | Receive lane to pins and receive logic, clock bit |
| rx_pos_o | output | WIDTH | Receive lane, positive rail |
| rx_neg_o | output | WIDTH | Receive lane, negative rail |
| mode_stat_o | output | 2 | Active loopback mode {local, remote} |

## Verification
The bench builds the block with WIDTH=3 and AFE_STAGES=2. The multi-bit rails show whether any route swaps or drops rail bits. A two-deep front-end chain separates the delays of the four routes: 1, 3 and 4 cycles. A lane that takes the wrong path therefore arrives at the wrong time and is caught. Random mode holds, including short ones, exercise the registered mode update. Data is checked only once a mode has been held long enough to fill every route.

// File: rtl/lbk_pkg.sv
// Package: shared mode encoding for the loopback selector.
// Assumes the mode code is {local_enable, remote_enable}.
package lbk_pkg;
    typedef enum logic [1:0] {
        LBK_OFF    = 2'b00,
        LBK_REMOTE = 2'b01,
        LBK_ALOCAL = 2'b10,
        LBK_DLOCAL = 2'b11
    } lbk_mode_e;
endpackage

// File: rtl/lbk_mode_reg.sv
// Module: captures the two loopback control bits into the active mode.
// Assumes the controls are synchronous to clk; reset selects no loopback.
module lbk_mode_reg
    import lbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      loc_en,
    input  logic      rem_en,
    output lbk_mode_e mode_q
);
    // Register the control code so every route switches on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= LBK_OFF;
        else        mode_q <= lbk_mode_e'({loc_en, rem_en});
    end

    // R1: mode follows the control bits sampled one edge earlier
    a_r1_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mode_q == lbk_mode_e'($past({loc_en, rem_en}))));
endmodule

// File: rtl/lbk_lane_reg.sv
// Module: registered 2:1 lane multiplexer (sel=0 picks a, sel=1 picks b).
// Assumes both inputs are synchronous to clk.
module lbk_lane_reg #(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] q
);
    // Capture the selected lane; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (sel) q <= b;
        else          q <= a;
    end
endmodule

// File: rtl/lbk_afe_stub.sv
// Module: digital stand-in for the analog receive front end, a fixed
// register delay of STAGES cycles (STAGES=0 is a straight wire).
module lbk_afe_stub #(
    parameter int LW     = 3,
    parameter int STAGES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] d,
    output logic [LW-1:0] q
);
    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_chain
            logic [LW-1:0] pipe [STAGES];
            // Shift the lane through the delay chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lbk_selector.sv
// Module: loopback selector top. It routes a {clock, pos, neg} lane between
// the transmit pins, the line, the front-end stub and the receive outputs.
// Assumes all lanes are sampled on clk; line coding, signal-loss detection
// and pattern checking sit downstream of the rx_* outputs.
module lbk_selector
    import lbk_pkg::*;
#(
    parameter int WIDTH      = 1,
    parameter int AFE_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_en_i,
    input  logic             rem_en_i,
    input  logic             tx_clk_i,
    input  logic [WIDTH-1:0] tx_pos_i,
    input  logic [WIDTH-1:0] tx_neg_i,
    input  logic             line_rx_clk_i,
    input  logic [WIDTH-1:0] line_rx_pos_i,
    input  logic [WIDTH-1:0] line_rx_neg_i,
    output logic             line_tx_clk_o,
    output logic [WIDTH-1:0] line_tx_pos_o,
    output logic [WIDTH-1:0] line_tx_neg_o,
    output logic             rx_clk_o,
    output logic [WIDTH-1:0] rx_pos_o,
    output logic [WIDTH-1:0] rx_neg_o,
    output logic [1:0]       mode_stat_o
);
    localparam int LW = 2 * WIDTH + 1;

    lbk_mode_e     mode_q;
    logic [LW-1:0] tx_lane, lrx_lane, afe_in, rcv_lane, line_lane, rx_lane;

    // Pack the incoming lanes.
    assign tx_lane  = {tx_clk_i, tx_pos_i, tx_neg_i};
    assign lrx_lane = {line_rx_clk_i, line_rx_pos_i, line_rx_neg_i};

    lbk_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .loc_en (loc_en_i),
        .rem_en (rem_en_i),
        .mode_q (mode_q)
    );

    // Front-end input: the outgoing line lane in analog local mode, else the line.
    assign afe_in = (mode_q == LBK_ALOCAL) ? line_lane : lrx_lane;

    lbk_afe_stub #(.LW(LW), .STAGES(AFE_STAGES)) u_afe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (afe_in),
        .q     (rcv_lane)
    );

    // Line output: the recovered lane in remote mode, else the transmit lane.
    lbk_lane_reg #(.LW(LW)) u_line_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (mode_q == LBK_REMOTE),
        .a     (tx_lane),
        .b     (rcv_lane),
        .q     (line_lane)
    );

    // Receive output: the transmit lane in digital local mode, else the recovered lane.
    lbk_lane_reg #(.LW(LW)) u_rx_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (mode_q == LBK_DLOCAL),
        .a     (rcv_lane),
        .b     (tx_lane),
        .q     (rx_lane)
    );

    // Unpack the outgoing lanes and the status.
    assign {line_tx_clk_o, line_tx_pos_o, line_tx_neg_o} = line_lane;
    assign {rx_clk_o, rx_pos_o, rx_neg_o}                = rx_lane;
    assign mode_stat_o                                   = mode_q;

    // R2: with loopback off, the transmit lane reaches the line after one cycle
    a_r2_off_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LBK_OFF) |=> (line_lane == $past(tx_lane)));
    // R3: remote mode sends the recovered lane to the line
    a_r3_remote_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LBK_REMOTE) |=> (line_lane == $past(rcv_lane)));
    // R4: remote mode still delivers the recovered lane to the receive outputs
    a_r4_remote_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LBK_REMOTE) |=> (rx_lane == $past(rcv_lane)));
    // R6: digital local mode feeds the transmit lane to the receive outputs
    a_r6_dlocal_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LBK_DLOCAL) |=> (rx_lane == $past(tx_lane)));
    // R7: both local modes keep the line driven from the transmit lane
    a_r7_local_line: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |=> (line_lane == $past(tx_lane)));
endmodule

// File: tb/lbk_selector_test.sv
module lbk_selector_test;
    localparam int W   = 3;
    localparam int AFE = 2;
    localparam int LW  = 2 * W + 1;
    localparam int HN  = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, loc_en, rem_en;
    logic         tx_clk, lrx_clk;
    logic [W-1:0] tx_pos, tx_neg, lrx_pos, lrx_neg;
    logic         ltx_clk, rx_clk;
    logic [W-1:0] ltx_pos, ltx_neg, rx_pos, rx_neg;
    logic [1:0]   mode_stat;

    lbk_selector #(.WIDTH(W), .AFE_STAGES(AFE)) uut (
        .clk(clk), .rst_n(rst_n), .loc_en_i(loc_en), .rem_en_i(rem_en),
        .tx_clk_i(tx_clk), .tx_pos_i(tx_pos), .tx_neg_i(tx_neg),
        .line_rx_clk_i(lrx_clk), .line_rx_pos_i(lrx_pos), .line_rx_neg_i(lrx_neg),
        .line_tx_clk_o(ltx_clk), .line_tx_pos_o(ltx_pos), .line_tx_neg_o(ltx_neg),
        .rx_clk_o(rx_clk), .rx_pos_o(rx_pos), .rx_neg_o(rx_neg),
        .mode_stat_o(mode_stat)
    );

    wire [LW-1:0] tx_lane  = {tx_clk, tx_pos, tx_neg};
    wire [LW-1:0] lrx_lane = {lrx_clk, lrx_pos, lrx_neg};
    wire [LW-1:0] ltx_lane = {ltx_clk, ltx_pos, ltx_neg};
    wire [LW-1:0] rx_lane  = {rx_clk, rx_pos, rx_neg};

    logic [LW-1:0] txh [HN];
    logic [LW-1:0] rxh [HN];
    logic [1:0]    ctlh [HN];
    int n = 100;
    int stable = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Expected line output for a settled mode at edge index k.
    function automatic logic [LW-1:0] exp_line(input logic [1:0] m, input int k);
        if (m == 2'b01) return rxh[(k - AFE) % HN];
        return txh[k % HN];
    endfunction

    // Expected receive output for a settled mode at edge index k.
    function automatic logic [LW-1:0] exp_rx(input logic [1:0] m, input int k);
        case (m)
            2'b10:   return txh[(k - AFE - 1) % HN];
            2'b11:   return txh[k % HN];
            default: return rxh[(k - AFE) % HN];
        endcase
    endfunction

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, n);
        end
    endtask

    task automatic randomize_data();
        {tx_clk, tx_pos, tx_neg}    = LW'($urandom());
        {lrx_clk, lrx_pos, lrx_neg} = LW'($urandom());
    endtask

    // One clock: record the inputs taken at the edge, then check the outputs.
    task automatic step();
        int prev;
        logic [1:0] m;
        @(posedge clk);
        n++;
        txh[n % HN]  = tx_lane;
        rxh[n % HN]  = lrx_lane;
        ctlh[n % HN] = {loc_en, rem_en};
        prev = stable;
        if (!rst_n) stable = 0;
        else if (stable > 0 && ctlh[n % HN] == ctlh[(n - 1) % HN]) stable++;
        else stable = 1;
        #1;
        if (!rst_n) return;
        check("R1 mode status", LW'(mode_stat), LW'(ctlh[n % HN]));
        if (prev >= AFE + 3) begin
            m = ctlh[(n - 1) % HN];
            case (m)
                2'b00: begin
                    check("R2 off line", ltx_lane, exp_line(m, n));
                    check("R2 off rx", rx_lane, exp_rx(m, n));
                end
                2'b01: begin
                    check("R3 remote line", ltx_lane, exp_line(m, n));
                    check("R4 remote rx", rx_lane, exp_rx(m, n));
                end
                2'b10: begin
                    check("R7 alocal line", ltx_lane, exp_line(m, n));
                    check("R5 alocal rx", rx_lane, exp_rx(m, n));
                end
                default: begin
                    check("R7 dlocal line", ltx_lane, exp_line(m, n));
                    check("R6 dlocal rx", rx_lane, exp_rx(m, n));
                end
            endcase
        end
    endtask

    task automatic reset_pulse();
        rst_n = 1'b0;
        randomize_data();
        loc_en = $urandom() % 2;
        rem_en = $urandom() % 2;
        step();
        step();
        #1;
        // R8: every output lane and the status are cleared by reset
        check("R8 reset line", ltx_lane, '0);
        check("R8 reset rx", rx_lane, '0);
        check("R8 reset status", LW'(mode_stat), '0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        loc_en = 1'b0;
        rem_en = 1'b0;
        randomize_data();
        reset_pulse();
        // Directed: hold each mode with random data in both lanes.
        for (int md = 0; md < 4; md++) begin
            {loc_en, rem_en} = 2'(md);
            for (int c = 0; c < 20; c++) begin
                randomize_data();
                step();
            end
        end
        // Directed: remote with a constant line lane and a toggling transmit
        // lane, so the transmit input must not show up on the line (R3).
        {loc_en, rem_en} = 2'b01;
        {lrx_clk, lrx_pos, lrx_neg} = '1;
        for (int c = 0; c < 12; c++) begin
            {tx_clk, tx_pos, tx_neg} = LW'($urandom());
            step();
        end
        // Directed: local modes with a toggling line lane (R5, R6).
        for (int md = 2; md < 4; md++) begin
            {loc_en, rem_en} = 2'(md);
            {tx_clk, tx_pos, tx_neg} = '0;
            for (int c = 0; c < 12; c++) begin
                {lrx_clk, lrx_pos, lrx_neg} = LW'($urandom());
                step();
            end
        end
        reset_pulse();
        // Random: mode holds of varying length, some too short to settle.
        for (int seg = 0; seg < 150; seg++) begin
            {loc_en, rem_en} = 2'($urandom());
            for (int c = 0; c < 2 + int'($urandom() % 16); c++) begin
                randomize_data();
                step();
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule